// File: doc/BRIEF.md
# Packet-Boundary Reset Controller

This block wraps the single register stage at the output of a packet transmit engine. The stage faces a stream interface with valid, ready and last handshaking. The block accepts two reset requests that behave differently. A bus reset empties the stage at the next clock edge, whatever it holds, because the link is being reset as well. A logic reset never truncates a packet on the link. It lets the packet in flight finish, then empties the stage. While it waits, it refuses to start any new packet.

A done indication tells the engine that the reset sequence has completed and that transmission may resume. All resets are synchronous. Only the handshake is modelled. Payload bits pass through untouched.

Top module: `pkt_rst_ctrl`

## Requirements
- R1: When `bus_rst` is high at a clock edge, the stage is emptied at that edge, even in the middle of a packet: `dn_valid` and `rst_done` are low in the following cycle. `up_ready` is low for as long as `bus_rst` is high.
- R2: In normal operation, a beat accepted upstream (`up_valid` and `up_ready` high) appears on `dn_data`/`dn_last` with `dn_valid` high one cycle later. It is held unchanged while `dn_ready` is low. `up_ready` is low exactly when the stage is full and `dn_ready` is low.
- R3: A logic reset asserted in the middle of a packet does not empty the stage before the end-of-packet beat has left downstream. Upstream beats of that packet are still accepted until its last beat.
- R4: A logic reset sampled while no packet is in progress and the stage is empty or draining takes effect at that same clock edge. There is no wait.
- R5: While a logic reset is pending and the upstream packet has completed, `up_ready` is low, so no new packet can begin.
- R6: Once the stage has been cleared by a reset, `dn_valid` is low and the held beat is discarded.
- R7: A bus reset that arrives while a logic reset is still waiting completes the reset at once. It also clears any record of a packet in progress.
- R8: `rst_done` goes low at the edge where either reset input is sampled high. It stays low while either input is high. It rises at the first edge after the clear at which both inputs are low, and then stays high until the next reset. `up_ready` is low while `rst_done` is low, except while a pending logic reset is letting the current packet finish.
- R9: An end-of-packet beat counts as transferred only when `dn_valid`, `dn_last` and `dn_ready` are all high in the same cycle. While `dn_ready` is low, a pending logic reset keeps waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_rst | input | 1 | Immediate reset request, synchronous, active high |
| logic_rst | input | 1 | Packet-safe reset request, synchronous, active high |
| up_valid | input | 1 | Upstream beat valid |
| up_data | input | DATA_W | Upstream beat payload |
| up_last | input | 1 | Upstream beat is the end of its packet |
| up_ready | output | 1 | Stage accepts an upstream beat |
| dn_valid | output | 1 | Downstream beat valid |
| dn_data | output | DATA_W | Downstream beat payload |
| dn_last | output | 1 | Downstream beat ends its packet |
| dn_ready | input | 1 | Downstream accepts the beat |
| rst_done | output | 1 | Reset sequence finished, transmission allowed |

## Verification
The reset function is driven from four starting points: an idle stage, a packet mid-flight with downstream ready, a packet whose last beat is stalled by downstream, and a packet stuck mid-flight when a bus reset lands on a pending logic reset. The idle case separates an immediate clear from a deferred one. The mid-flight cases show whether the clear waits for the actual end-of-packet transfer rather than the upstream last beat. The stalled and overlapping cases separate the priority of the two reset classes and confirm that packet tracking is cleared. A plain pass-through pattern with backpressure pins down the stage timing that all the other checks count on.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CLEAN = 2'd2
    } prc_state_e;

    typedef struct packed {
        logic flush;
        logic block;
        logic done;
    } prc_ctl_t;

    // Safe to empty the stage: upstream packet closed and the held beat
    // (if any) leaves downstream this cycle.
    function automatic logic drain_ok(input logic mid, input logic full, input logic take);
        return !mid && (!full || take);
    endfunction

endpackage

// File: rtl/prc_stage.sv
module prc_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready
);
    localparam int BEAT_W = DATA_W + 1;

    logic              full_q;
    logic [BEAT_W-1:0] beat_q;
    logic              load;

    assign in_ready  = !full_q || out_ready;
    assign load      = in_valid && in_ready;
    assign out_valid = full_q;
    assign out_data  = beat_q[DATA_W-1:0];
    assign out_last  = beat_q[DATA_W];

    always_ff @(posedge clk) begin
        if (flush)          full_q <= 1'b0;
        else if (load)      full_q <= 1'b1;
        else if (out_ready) full_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (load) beat_q <= {in_last, in_data};
    end

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (flush)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R2

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (1'b0)
        flush |=> !out_valid); // R6

endmodule

// File: rtl/prc_track.sv
module prc_track (
    input  logic clk,
    input  logic clr,
    input  logic acc,
    input  logic acc_last,
    output logic mid
);
    logic mid_q;

    always_ff @(posedge clk) begin
        if (clr)      mid_q <= 1'b0;
        else if (acc) mid_q <= !acc_last;
    end

    assign mid = mid_q;

    AST_MID_OPEN: assert property (@(posedge clk) disable iff (clr)
        (acc && !acc_last) |=> mid); // R3

endmodule

// File: rtl/prc_seq.sv
module prc_seq
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       bus_rst,
    input  logic       logic_rst,
    input  logic       mid,
    input  logic       full,
    input  logic       take,
    output prc_ctl_t   ctl,
    output prc_state_e state
);
    prc_state_e state_q, state_d;
    logic       req;
    logic       clr_ok;

    assign req    = logic_rst || (state_q == ST_WAIT);
    assign clr_ok = drain_ok(mid, full, take);

    always_comb begin
        state_d = state_q;
        if (bus_rst)                 state_d = ST_CLEAN;
        else if (req)                state_d = clr_ok ? ST_CLEAN : ST_WAIT;
        else if (state_q == ST_CLEAN) state_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        ctl.flush = bus_rst || (req && clr_ok);
        ctl.block = bus_rst || (state_q == ST_CLEAN) || (req && !mid);
        ctl.done  = (state_q == ST_RUN);
    end

    assign state = state_q;

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (1'b0)
        (bus_rst || logic_rst) |=> !ctl.done); // R8

    AST_DONE_RISE: assert property (@(posedge clk) disable iff (bus_rst)
        $rose(ctl.done) |-> (!$past(logic_rst) && !$past(bus_rst))); // R8

    AST_BUS_WINS: assert property (@(posedge clk) disable iff (1'b0)
        (bus_rst && state_q == ST_WAIT) |=> (state_q == ST_CLEAN)); // R7

endmodule

// File: rtl/pkt_rst_ctrl.sv
module pkt_rst_ctrl
    import prc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              bus_rst,
    input  logic              logic_rst,
    input  logic              up_valid,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_last,
    output logic              up_ready,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_last,
    input  logic              dn_ready,
    output logic              rst_done
);
    prc_ctl_t   ctl;
    prc_state_e state;
    logic       stage_rdy;
    logic       stage_in_valid;
    logic       up_mid;
    logic       up_acc;

    assign stage_in_valid = up_valid && !ctl.block;
    assign up_ready       = stage_rdy && !ctl.block;
    assign up_acc         = up_valid && up_ready;
    assign rst_done       = ctl.done;

    prc_stage #(.DATA_W(DATA_W)) u_stage (
        .clk      (clk),
        .flush    (ctl.flush),
        .in_valid (stage_in_valid),
        .in_data  (up_data),
        .in_last  (up_last),
        .in_ready (stage_rdy),
        .out_valid(dn_valid),
        .out_data (dn_data),
        .out_last (dn_last),
        .out_ready(dn_ready)
    );

    prc_track u_track (
        .clk     (clk),
        .clr     (ctl.flush),
        .acc     (up_acc),
        .acc_last(up_last),
        .mid     (up_mid)
    );

    prc_seq u_seq (
        .clk      (clk),
        .bus_rst  (bus_rst),
        .logic_rst(logic_rst),
        .mid      (up_mid),
        .full     (dn_valid),
        .take     (dn_ready),
        .ctl      (ctl),
        .state    (state)
    );

    // Downstream packet tracker, used only by the checks below.
    logic dn_mid_q;
    always_ff @(posedge clk) begin
        if (bus_rst)                   dn_mid_q <= 1'b0;
        else if (dn_valid && dn_ready) dn_mid_q <= !dn_last;
    end

    AST_NO_TRUNC: assert property (@(posedge clk) disable iff (bus_rst)
        ctl.flush |-> (!dn_mid_q || (dn_valid && dn_ready && dn_last))); // R3

    AST_NO_DROP: assert property (@(posedge clk) disable iff (bus_rst)
        ctl.flush |-> (!dn_valid || dn_ready)); // R9

    AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (bus_rst)
        $past(bus_rst) |-> (!dn_valid && !rst_done)); // R1

    AST_GATE_NEW: assert property (@(posedge clk) disable iff (bus_rst)
        (state == ST_WAIT && !up_mid) |-> !up_ready); // R5

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (bus_rst)
        (logic_rst && !up_mid && !dn_valid) |=> (!dn_valid && !rst_done)); // R4

endmodule

// File: tb/pkt_rst_ctrl_tb.sv
module pkt_rst_ctrl_tb;
    localparam int  DW     = 32;
    localparam time CLK_PD = 10ns;

    logic          clk = 1'b0;
    logic          bus_rst = 1'b0, logic_rst = 1'b0;
    logic          up_valid = 1'b0, up_last = 1'b0, dn_ready = 1'b0;
    logic [DW-1:0] up_data = '0;
    logic          up_ready, dn_valid, dn_last, rst_done;
    logic [DW-1:0] dn_data;

    int total = 0;
    int bad   = 0;

    always #(CLK_PD/2) clk = ~clk;

    pkt_rst_ctrl #(.DATA_W(DW)) u_dut (
        .clk(clk), .bus_rst(bus_rst), .logic_rst(logic_rst),
        .up_valid(up_valid), .up_data(up_data), .up_last(up_last), .up_ready(up_ready),
        .dn_valid(dn_valid), .dn_data(dn_data), .dn_last(dn_last), .dn_ready(dn_ready),
        .rst_done(rst_done)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic beat(input logic v, input logic [DW-1:0] d, input logic l);
        up_valid = v; up_data = d; up_last = l;
    endtask

    task automatic t_reset();
        bus_rst = 1'b1;
        #1 chk("R1", "up_ready in bus reset", up_ready, 0);
        tick(); tick();
        chk("R1", "dn_valid after reset", dn_valid, 0);
        chk("R8", "done during reset", rst_done, 0);
        bus_rst = 1'b0;
        tick();
        chk("R8", "done after release", rst_done, 1);
        chk("R8", "up_ready after release", up_ready, 1);
    endtask

    task automatic t_pass();
        dn_ready = 1'b1; beat(1, 32'h11, 1);
        #1 chk("R2", "up_ready empty stage", up_ready, 1);
        tick();
        chk("R2", "dn_valid", dn_valid, 1);
        chk("R2", "dn_data", dn_data, 32'h11);
        chk("R2", "dn_last", dn_last, 1);
        dn_ready = 1'b0; beat(1, 32'h22, 0);
        #1 chk("R2", "up_ready full stalled", up_ready, 0);
        tick();
        chk("R2", "held data", dn_data, 32'h11);
        dn_ready = 1'b1;
        tick();
        chk("R2", "next data", dn_data, 32'h22);
        beat(1, 32'h33, 1);
        tick();
        beat(0, 0, 0);
        tick();
        chk("R2", "drained", dn_valid, 0);
    endtask

    task automatic t_idle();
        logic_rst = 1'b1;
        #1 chk("R5", "up_ready on idle logic reset", up_ready, 0);
        tick();
        chk("R4", "stage empty", dn_valid, 0);
        chk("R4", "done low", rst_done, 0);
        tick();
        chk("R8", "done low while held", rst_done, 0);
        logic_rst = 1'b0;
        tick();
        chk("R8", "done back", rst_done, 1);
    endtask

    task automatic t_mid();
        dn_ready = 1'b1; beat(1, 32'hA1, 0);
        tick();
        logic_rst = 1'b1; beat(1, 32'hA2, 0);
        #1 chk("R3", "up_ready mid packet", up_ready, 1);
        tick();
        logic_rst = 1'b0; beat(1, 32'hA3, 1);
        #1 chk("R3", "up_ready for last", up_ready, 1);
        tick();
        beat(1, 32'hB1, 0); dn_ready = 1'b0;
        #1 chk("R5", "new packet blocked", up_ready, 0);
        chk("R3", "last beat present", dn_data, 32'hA3);
        tick();
        chk("R9", "stalled last kept", dn_valid, 1);
        chk("R9", "stalled last flag", dn_last, 1);
        chk("R9", "done low while stalled", rst_done, 0);
        dn_ready = 1'b1; beat(0, 0, 0);
        tick();
        chk("R6", "cleared after last", dn_valid, 0);
        chk("R8", "done one cycle later", rst_done, 0);
        tick();
        chk("R8", "done after clear", rst_done, 1);
    endtask

    task automatic t_bus_mid();
        dn_ready = 1'b0; beat(1, 32'h55, 0);
        tick();
        beat(1, 32'h56, 0); bus_rst = 1'b1;
        #1 chk("R1", "up_ready in bus reset", up_ready, 0);
        tick();
        chk("R1", "mid packet dropped", dn_valid, 0);
        chk("R1", "done low", rst_done, 0);
        bus_rst = 1'b0; beat(0, 0, 0);
        tick();
        chk("R1", "done after bus", rst_done, 1);
    endtask

    task automatic t_prio();
        dn_ready = 1'b0; beat(1, 32'h77, 0);
        tick();
        beat(0, 0, 0); logic_rst = 1'b1;
        tick();
        logic_rst = 1'b0;
        tick(); tick();
        chk("R3", "still waiting", dn_valid, 1);
        chk("R3", "done low waiting", rst_done, 0);
        bus_rst = 1'b1;
        tick();
        chk("R7", "bus overrides", dn_valid, 0);
        bus_rst = 1'b0;
        tick();
        chk("R7", "done after override", rst_done, 1);
        logic_rst = 1'b1;
        tick();
        logic_rst = 1'b0;
        tick();
        chk("R7", "packet record cleared", rst_done, 1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pass();
        t_idle();
        t_mid();
        t_bus_mid();
        t_prio();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule